// File: doc/BRIEF.md
# Frame Sync Word Detector

This block watches a serial stream of demodulated bits and flags the point where a 16-bit frame synchronisation word has just gone by. The word is held in a register that the host fills from two bytes of its data buffer. The first byte holds the earlier half of the word, with its most significant bit matched against the earliest received bit. The second byte holds the later half, with its least significant bit matched against the most recent bit. Loading the word only stores it. A separate search command starts detection.

A search runs in one of two modes. In the tolerant mode a window counts as a match when the number of positions that differ from the stored word is no more than a parameter (default 1). In the strict mode every one of the 16 positions must agree. Once a match is reported the search stops, and the host must issue a new search command before another match can be reported. After accepting a load, the block raises a buffer-free flag and an interrupt flag so the host knows it may write again. Loads are meant to happen between messages. A load that arrives while a search is running is rejected and latches an error flag.

Top module: `fsync_detect`

## Requirements
- R1: After reset `searching`, `sync_found`, `irq` and `load_err` are 0 and `buf_free` is 1.
- R2: A `load_req` pulse while no search is active stores the word {`byte0`, `byte1`}. Bit 7 of `byte0` is compared with the earliest of the 16 window bits, and bit 0 of `byte1` with the most recent.
- R3: An accepted load sets `buf_free` and `irq` to 1 in the next cycle. `buf_wr` clears `buf_free` and `irq_ack` clears `irq`, each one cycle later.
- R4: Loading the word does not start a search, so `searching` stays 0 and `sync_found` does not pulse.
- R5: In tolerant mode (`search_strict` = 0) a match is reported when the window differs from the word in at most `MAX_ERR` positions (default 1).
- R6: In strict mode (`search_strict` = 1) a match is reported only when all 16 positions agree.
- R7: A match can only be reported on or after the 16th valid bit received since the latest search command.
- R8: A match gives a one-cycle `sync_found` pulse in the cycle after the completing bit, and `searching` drops in that same cycle. No further pulse follows until a new search command.
- R9: A `load_req` while a search is active leaves the word, `buf_free` and `irq` unchanged and sets `load_err`, which stays set until reset.
- R10: A bit presented with `bit_valid` = 0 neither shifts the window nor counts toward R7.
- R11: A `search_req` while a search is active restarts the search, and the count of R7 begins again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Received bit |
| load_req | input | 1 | Take the sync word from the two buffer bytes |
| byte0 | input | 8 | Buffer byte holding the earlier half of the word |
| byte1 | input | 8 | Buffer byte holding the later half of the word |
| buf_wr | input | 1 | Host has written the buffer; clears `buf_free` |
| irq_ack | input | 1 | Clears `irq` |
| search_req | input | 1 | Start or restart a search |
| search_strict | input | 1 | Mode for the search being started: 1 strict, 0 tolerant |
| searching | output | 1 | A search is active |
| sync_found | output | 1 | One-cycle match pulse |
| buf_free | output | 1 | Buffer may be written |
| irq | output | 1 | Interrupt flag raised by an accepted load |
| load_err | output | 1 | Sticky flag for a load rejected during a search |

## Verification
Assertions check several rules on every cycle. A match pulse always ends the search and is never followed by a second pulse. A match requires a qualified bit, a full window and a mismatch count within the limit of the active mode. A load during a search leaves the stored word untouched and raises the error flag, and an accepted load always raises both handshake flags. Only the bench can show that the bit ordering between the bytes and the window is correct. It also shows, over real streams, that a match is reported at exactly the right bit, that the strict and tolerant modes differ on the same stream, and that a rejected load has no effect on later detection.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
   typedef enum logic {
      MODE_TOLERANT = 1'b0,
      MODE_STRICT   = 1'b1
   } srch_mode_e;
endpackage

// File: rtl/fsync_pattern_reg.sv
module fsync_pattern_reg #(
   parameter int                    BYTE_W        = 8,
   parameter int                    NBYTES        = 2,
   parameter logic [NBYTES*BYTE_W-1:0] RESET_PATTERN = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_en,
   input  logic [NBYTES*BYTE_W-1:0] bytes_flat,
   output logic [NBYTES*BYTE_W-1:0] pattern
);
   localparam int PAT_W = NBYTES * BYTE_W;

   // Byte k of the buffer feeds the k-th slice counted from the earliest-bit end.
   for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      localparam int HI = PAT_W - 1 - k * BYTE_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pattern[HI -: BYTE_W] <= RESET_PATTERN[HI -: BYTE_W];
         else if (load_en)
            pattern[HI -: BYTE_W] <= bytes_flat[HI -: BYTE_W];
      end
   end
endmodule

// File: rtl/fsync_window.sv
module fsync_window #(
   parameter int PAT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             bit_in,
   input  logic             restart,
   output logic [PAT_W-1:0] window,
   output logic [PAT_W-1:0] next_window,
   output logic             ready_next
);
   localparam int CNT_W = $clog2(PAT_W + 1);
   localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(PAT_W - 1);

   logic [CNT_W-1:0] fill_cnt;

   assign next_window = {window[PAT_W-2:0], bit_in};
   // The incoming bit completes a full window since the last restart.
   assign ready_next  = (fill_cnt >= FULL_M1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         window <= '0;
      else if (shift_en)
         window <= next_window;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fill_cnt <= '0;
      else if (restart)
         fill_cnt <= '0;
      else if (shift_en && (fill_cnt != CNT_W'(PAT_W)))
         fill_cnt <= fill_cnt + 1'b1;
   end
endmodule

// File: rtl/fsync_compare.sv
module fsync_compare #(
   parameter int PAT_W   = 16,
   parameter int MAX_ERR = 1
) (
   input  logic [PAT_W-1:0] cand,
   input  logic [PAT_W-1:0] pattern,
   output logic             zero_diff,
   output logic             within_lim
);
   localparam int CNT_W = $clog2(PAT_W + 1);

   logic [PAT_W-1:0] diff;
   assign diff      = cand ^ pattern;
   assign zero_diff = (diff == '0);

   if (MAX_ERR == 0) begin : g_exact
      assign within_lim = zero_diff;
   end else begin : g_popcnt
      logic [CNT_W-1:0] n_diff;
      always_comb begin
         n_diff = '0;
         for (int i = 0; i < PAT_W; i++)
            n_diff = n_diff + CNT_W'(diff[i]);
      end
      assign within_lim = (n_diff <= CNT_W'(MAX_ERR));
   end
endmodule

// File: rtl/fsync_detect.sv
module fsync_detect
   import fsync_pkg::*;
#(
   parameter int          BYTE_W        = 8,
   parameter int          NBYTES        = 2,
   parameter int          MAX_ERR       = 1,
   parameter logic [15:0] RESET_PATTERN = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_valid,
   input  logic              bit_in,
   input  logic              load_req,
   input  logic [BYTE_W-1:0] byte0,
   input  logic [BYTE_W-1:0] byte1,
   input  logic              buf_wr,
   input  logic              irq_ack,
   input  logic              search_req,
   input  logic              search_strict,
   output logic              searching,
   output logic              sync_found,
   output logic              buf_free,
   output logic              irq,
   output logic              load_err
);
   localparam int PAT_W = NBYTES * BYTE_W;

   if (NBYTES != 2) begin : g_bad_nbytes
      $error("fsync_detect: the word is taken from exactly two buffer bytes");
   end
   if (PAT_W != 16) begin : g_bad_width
      $error("fsync_detect: the sync word must be 16 bits");
   end
   if (MAX_ERR < 0 || MAX_ERR >= PAT_W) begin : g_bad_err
      $error("fsync_detect: MAX_ERR out of range");
   end

   logic [PAT_W-1:0] pattern, window, next_window;
   logic             ready_next, zero_diff, within_lim;
   logic             load_ok, hit;
   srch_mode_e       mode;

   assign load_ok = load_req && !searching;

   fsync_pattern_reg #(
      .BYTE_W(BYTE_W), .NBYTES(NBYTES), .RESET_PATTERN(RESET_PATTERN)
   ) u_pat (
      .clk(clk), .rst_n(rst_n), .load_en(load_ok),
      .bytes_flat({byte0, byte1}), .pattern(pattern)
   );

   fsync_window #(.PAT_W(PAT_W)) u_win (
      .clk(clk), .rst_n(rst_n), .shift_en(bit_valid), .bit_in(bit_in),
      .restart(search_req), .window(window), .next_window(next_window),
      .ready_next(ready_next)
   );

   fsync_compare #(.PAT_W(PAT_W), .MAX_ERR(MAX_ERR)) u_cmp (
      .cand(next_window), .pattern(pattern),
      .zero_diff(zero_diff), .within_lim(within_lim)
   );

   assign hit = searching && bit_valid && ready_next &&
                ((mode == MODE_STRICT) ? zero_diff : within_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         searching  <= 1'b0;
         sync_found <= 1'b0;
         mode       <= MODE_TOLERANT;
      end else begin
         sync_found <= 1'b0;
         if (search_req) begin
            searching <= 1'b1;
            mode      <= srch_mode_e'(search_strict);
         end else if (hit) begin
            searching  <= 1'b0;
            sync_found <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_free <= 1'b1;
         irq      <= 1'b0;
         load_err <= 1'b0;
      end else begin
         if (load_ok)     buf_free <= 1'b1;
         else if (buf_wr) buf_free <= 1'b0;
         if (load_ok)      irq <= 1'b1;
         else if (irq_ack) irq <= 1'b0;
         if (load_req && searching) load_err <= 1'b1;
      end
   end

   a_r2_load_stores_word: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && !searching) |=> (pattern == $past({byte0, byte1})));
   a_r3_load_raises_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && !searching) |=> (buf_free && irq));
   a_r4_load_no_search: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && !searching && !search_req) |=> !searching);
   a_r5_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
      sync_found |-> $past(within_lim));
   a_r6_strict_exact: assert property (@(posedge clk) disable iff (!rst_n)
      (searching && mode == MODE_STRICT && !search_req && !zero_diff) |=> !sync_found);
   a_r7_full_window: assert property (@(posedge clk) disable iff (!rst_n)
      sync_found |-> $past(ready_next));
   a_r8_found_ends_search: assert property (@(posedge clk) disable iff (!rst_n)
      sync_found |-> !searching);
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sync_found |=> !sync_found);
   a_r9_busy_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && searching) |=> (load_err && $stable(pattern)));
   a_r10_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_valid && !search_req) |=> !sync_found);
endmodule

// File: tb/tb_fsync_detect.sv
`timescale 1ns/1ps
module tb_fsync_detect;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_valid = 1'b0, bit_in = 1'b0;
   logic       load_req = 1'b0;
   logic [7:0] byte0 = '0, byte1 = '0;
   logic       buf_wr = 1'b0, irq_ack = 1'b0;
   logic       search_req = 1'b0, search_strict = 1'b0;
   logic       searching, sync_found, buf_free, irq, load_err;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   fsync_detect dut (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .load_req(load_req), .byte0(byte0), .byte1(byte1), .buf_wr(buf_wr),
      .irq_ack(irq_ack), .search_req(search_req), .search_strict(search_strict),
      .searching(searching), .sync_found(sync_found), .buf_free(buf_free),
      .irq(irq), .load_err(load_err)
   );

   // {strict, word, 32-bit stream sent MSB first}
   localparam logic [48:0] VEC [8] = '{
      {1'b0, 16'hA5C3, 32'hA5C3_0000},
      {1'b0, 16'hA5C3, 32'h0A5C_3FFF},
      {1'b0, 16'hA5C3, 32'hA5C2_0000},
      {1'b1, 16'hA5C3, 32'hA5C2_0000},
      {1'b0, 16'hA5C3, 32'hA4C2_0000},
      {1'b1, 16'hFFFF, 32'h0000_FFFF},
      {1'b1, 16'h8001, 32'h8001_8001},
      {1'b0, 16'h1234, 32'h0000_0000}
   };

   task automatic chk(input bit ok, input string req, input int got, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s got=%0d expected=%0d", req, got, exp);
      end
   endtask

   function automatic int ref_pos(input logic [15:0] w, input logic [31:0] s,
                                  input bit strict);
      logic [15:0] win = '0;
      for (int k = 1; k <= 32; k++) begin
         win = {win[14:0], s[32-k]};
         if (k >= 16 && $countones(win ^ w) <= (strict ? 0 : 1)) return k;
      end
      return 0;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic load_word(input logic [15:0] w);
      byte0 = w[15:8]; byte1 = w[7:0]; load_req = 1'b1;
      @(negedge clk);
      load_req = 1'b0;
   endtask

   task automatic start_search(input bit strict);
      search_req = 1'b1; search_strict = strict;
      @(negedge clk);
      search_req = 1'b0;
   endtask

   task automatic send_bit(input logic b, output logic f);
      bit_valid = 1'b1; bit_in = b;
      @(negedge clk);
      f = sync_found;
      bit_valid = 1'b0;
   endtask

   // Sends n bits of s (MSB first); returns 1-based index of first pulse and pulse count.
   task automatic send_stream(input logic [31:0] s, input int n,
                              output int pos, output int pulses);
      logic f;
      pos = 0; pulses = 0;
      for (int k = 1; k <= n; k++) begin
         send_bit(s[n-k], f);
         if (f) begin
            pulses++;
            if (pos == 0) pos = k;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog got=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int pos, pulses, exp;
      logic f;
      do_reset();
      // R1 reset state
      chk(!searching && !sync_found && !irq && !load_err && buf_free, "R1",
          {searching, sync_found, buf_free, irq, load_err}, 5'b00100);

      // Table walk: R2 ordering, R5 tolerant, R6 strict, R7, R8
      for (int v = 0; v < 8; v++) begin
         do_reset();
         load_word(VEC[v][47:32]);
         chk(buf_free && irq, "R3", {buf_free, irq}, 2'b11);
         start_search(VEC[v][48]);
         send_stream(VEC[v][31:0], 32, pos, pulses);
         exp = ref_pos(VEC[v][47:32], VEC[v][31:0], VEC[v][48]);
         chk(pos == exp, VEC[v][48] ? "R6/R2" : "R5/R2", pos, exp);
         chk(pulses == (exp != 0 ? 1 : 0), "R8", pulses, exp != 0 ? 1 : 0);
      end

      // R3 flag clearing
      do_reset();
      load_word(16'h4E2D);
      buf_wr = 1'b1; @(negedge clk); buf_wr = 1'b0;
      chk(!buf_free && irq, "R3", {buf_free, irq}, 2'b01);
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      chk(!irq, "R3", irq, 0);

      // R4 load alone does not search
      send_stream({16'h0, 16'h4E2D}, 16, pos, pulses);
      chk(!searching && pulses == 0, "R4", pulses + 2 * searching, 0);

      // R9 load while searching: rejected, old word still detects
      start_search(1'b1);
      load_word(16'hFFFF);
      chk(load_err && !buf_free && !irq, "R9", {load_err, buf_free, irq}, 3'b100);
      send_stream({16'h0, 16'h4E2D}, 16, pos, pulses);
      chk(pos == 16, "R9", pos, 16);
      // R8: stream again, no second pulse
      send_stream({16'h0, 16'h4E2D}, 16, pos, pulses);
      chk(pulses == 0 && !searching, "R8", pulses, 0);
      chk(load_err, "R9", load_err, 1);

      // R7 zero word matches stale zeros only after 16 bits
      do_reset();
      load_word(16'h0000);
      start_search(1'b1);
      send_stream(32'h0, 16, pos, pulses);
      chk(pos == 16, "R7", pos, 16);

      // R10 unqualified bits ignored
      do_reset();
      load_word(16'hC35A);
      start_search(1'b0);
      for (int k = 15; k >= 0; k--) begin
         bit_valid = 1'b0; bit_in = ~bit_in;
         @(negedge clk);
         chk(!sync_found, "R10", sync_found, 0);
         send_bit(16'hC35A >> k & 1'b1, f);
         if (k != 0) chk(!f, "R10", f, 0);
         else        chk(f, "R10", f, 1);
      end

      // R11 restart clears the bit count
      do_reset();
      load_word(16'h6B91);
      start_search(1'b1);
      send_stream({17'h0, 15'(16'h6B91 >> 1)}, 15, pos, pulses);
      start_search(1'b1);
      send_bit(1'b1, f);
      chk(!f && searching, "R11", f, 0);
      send_stream({16'h0, 16'h6B91}, 16, pos, pulses);
      chk(pos == 16, "R11", pos, 16);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule